// File: doc/BRIEF.md
# Cache Miss Line-Fill Sequencer

This block handles a miss in a writeback, set-associative cache. The core reports a lookup and its hit result. On a miss the block captures the address and stalls the core. It reads the tag entries of the indexed set and picks a victim way. If that victim holds modified data, the block streams it out to the next memory level first. It then requests the missing line, collects it beat by beat from a narrow return bus into the data array, and writes the new tag entry in a separate cycle. Finally it releases the core with the requested bus-width word.

The tag and data arrays sit outside the block. The block addresses them through a shared set/way/beat index, reads them combinationally and writes them through enable strobes. The next level sees a one-cycle request pulse. The next level answers with one valid-qualified beat per data transfer and takes whatever latency it needs. During a writeback the block paces the outgoing beats itself, at a fixed number of cycles per beat.

Top module: `mfc_linefill_ctrl`

## Requirements
- R1: While reset is held and right after it is released, stall_o, resume_o, nl_req_o, nl_we_o, nl_wvalid_o, tag_we_o and data_we_o are all 0.
- R2: A miss (lk_valid_i=1, lk_hit_i=0 while idle) whose victim is clean drives nl_req_o high for exactly one cycle, two cycles after the miss cycle, with nl_we_o=0 and no write beat before it. nl_addr_o carries the line address {tag, set, zero offset}. The address layout is tag = addr[31:12], set = addr[11:6], offset = addr[5:0].
- R3: A valid and dirty victim is written back before the request. There are BEATS = LINE_BYTES/BUS_BYTES beats (4 by default), each lasting BEAT_CYC cycles (2). nl_wvalid_o pulses on the last cycle of each beat, and the beats come in order 0 to BEATS-1. nl_addr_o is the victim's line address, and nl_wdata_o carries the data-array word of that beat. The request follows in the cycle right after the last write beat.
- R4: After the request, each nl_rvalid_i beat is written into the data array in arrival order, as beat 0 to BEATS-1 of the chosen way of the missing set.
- R5: The cycle after the last returned beat, one tag write stores the new tag with valid=1 and dirty equal to lk_write_i of the miss (0 for a load, 1 for a store).
- R6: stall_o is high from the miss cycle through the tag-write cycle. resume_o pulses in the next cycle with the requested word, addr[5:4] selecting the beat. With a next level that answers REQ_LAT=10 cycles after the request and then one beat every BEAT_CYC cycles, stall lasts 22 cycles for a clean victim and 30 for a dirty one.
- R7: The victim is the lowest-numbered invalid way. When all ways are valid, a round-robin pointer is used instead. The pointer starts at way 0 after reset and advances by one at each such selection.
- R8: Lookups that hit, lookups made while a miss is in progress, and nl_rvalid_i outside the data-return phase cause no stall, request, or array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup present |
| lk_hit_i | input | 1 | Lookup hit result |
| lk_write_i | input | 1 | Lookup is a store |
| lk_addr_i | input | ADDR_W | Lookup byte address |
| stall_o | output | 1 | Core must hold |
| resume_o | output | 1 | Miss finished, word valid |
| resume_data_o | output | BUS_W | Requested word |
| arr_set_o | output | IDX_W | Set index for tag and data arrays |
| arr_way_o | output | WAY_W | Way index for data array and tag write |
| tag_rd_valid_i | input | WAYS | Valid bits of the indexed set |
| tag_rd_dirty_i | input | WAYS | Dirty bits of the indexed set |
| tag_rd_tag_i | input | WAYS*TAG_W | Tags of the indexed set, way 0 lowest |
| tag_we_o | output | 1 | Tag entry write strobe |
| tag_wtag_o | output | TAG_W | Tag to write |
| tag_wvalid_o | output | 1 | Valid bit to write |
| tag_wdirty_o | output | 1 | Dirty bit to write |
| data_beat_o | output | BEAT_W | Beat index within the line |
| data_rdata_i | input | BUS_W | Data array read word |
| data_we_o | output | 1 | Data array write strobe |
| data_wdata_o | output | BUS_W | Data array write word |
| nl_req_o | output | 1 | Line request pulse |
| nl_we_o | output | 1 | Writeback in progress |
| nl_addr_o | output | ADDR_W | Line address to next level |
| nl_wvalid_o | output | 1 | Writeback beat valid |
| nl_wdata_o | output | BUS_W | Writeback beat data |
| nl_rvalid_i | input | 1 | Returned beat valid |
| nl_rdata_i | input | BUS_W | Returned beat data |

## Verification
The sequence is tried with four kinds of miss. The first is a load into an empty set. The second is a miss that meets a partly filled set while the core keeps presenting a different address. The third is a store whose victim is dirty in a full set. The fourth is a load into the same full set after that. The first two check the lowest-invalid rule and that the captured address wins over later lookups. The dirty store is the only case that checks writeback order, beat pacing, the 8-cycle penalty difference and the dirty bit of the new entry. The final load checks that the round-robin pointer moved. Hits and stray return beats while idle are checked for having no effect.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    typedef enum logic [2:0] {
        MS_IDLE,
        MS_VICTIM,
        MS_WBACK,
        MS_REQ,
        MS_WAIT,
        MS_FILL
    } miss_state_e;
endpackage

// File: rtl/mfc_beat_seq.sv
module mfc_beat_seq #(
    parameter int BEATS    = 4,
    parameter int BEAT_CYC = 2,
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int PH_W    = (BEAT_CYC > 1) ? $clog2(BEAT_CYC) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic              beat_end_o,
    output logic              last_o
);
    typedef struct packed {
        logic [PH_W-1:0]   ph;
        logic [BEAT_W-1:0] beat;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ph_end;

    always_comb begin
        seq_d  = seq_q;
        ph_end = (seq_q.ph == PH_W'(BEAT_CYC - 1));
        if (!run_i) begin
            seq_d = '0;
        end else if (ph_end) begin
            seq_d.ph   = '0;
            seq_d.beat = (seq_q.beat == BEAT_W'(BEATS - 1)) ? '0 : seq_q.beat + 1'b1;
        end else begin
            seq_d.ph = seq_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign beat_o     = seq_q.beat;
    assign beat_end_o = run_i & ph_end;
    assign last_o     = beat_end_o & (seq_q.beat == BEAT_W'(BEATS - 1));

    // R3: a beat boundary is followed by a fresh phase, never another boundary
    if (BEAT_CYC > 1) begin : g_spacing
        a_r3_beat_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
            beat_end_o |=> !beat_end_o);
    end
endmodule

// File: rtl/mfc_way_pick.sv
module mfc_way_pick #(
    parameter int WAYS    = 4,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             all_valid_o
);
    logic found;

    always_comb begin
        all_valid_o = &valid_i;
        way_o       = rr_i;
        found       = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_i[w] && !found) begin
                way_o = WAY_W'(w);
                found = 1'b1;
            end
        end
    end

    // R7: with any free way present, the chosen way is a free one
    a_r7_free_way_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !all_valid_o |-> !valid_i[way_o]);
endmodule

// File: rtl/mfc_linefill_ctrl.sv
module mfc_linefill_ctrl
    import mfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BUS_BYTES  = 16,
    parameter int WAYS       = 4,
    parameter int SETS       = 64,
    parameter int BEAT_CYC   = 2,
    localparam int BEATS     = LINE_BYTES / BUS_BYTES,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int BOFF_W    = $clog2(BUS_BYTES),
    localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int BUS_W     = BUS_BYTES * 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  lk_valid_i,
    input  logic                  lk_hit_i,
    input  logic                  lk_write_i,
    input  logic [ADDR_W-1:0]     lk_addr_i,
    output logic                  stall_o,
    output logic                  resume_o,
    output logic [BUS_W-1:0]      resume_data_o,
    output logic [IDX_W-1:0]      arr_set_o,
    output logic [WAY_W-1:0]      arr_way_o,
    input  logic [WAYS-1:0]       tag_rd_valid_i,
    input  logic [WAYS-1:0]       tag_rd_dirty_i,
    input  logic [WAYS*TAG_W-1:0] tag_rd_tag_i,
    output logic                  tag_we_o,
    output logic [TAG_W-1:0]      tag_wtag_o,
    output logic                  tag_wvalid_o,
    output logic                  tag_wdirty_o,
    output logic [BEAT_W-1:0]     data_beat_o,
    input  logic [BUS_W-1:0]      data_rdata_i,
    output logic                  data_we_o,
    output logic [BUS_W-1:0]      data_wdata_o,
    output logic                  nl_req_o,
    output logic                  nl_we_o,
    output logic [ADDR_W-1:0]     nl_addr_o,
    output logic                  nl_wvalid_o,
    output logic [BUS_W-1:0]      nl_wdata_o,
    input  logic                  nl_rvalid_i,
    input  logic [BUS_W-1:0]      nl_rdata_i
);
    typedef struct packed {
        miss_state_e       st;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  set;
        logic [BEAT_W-1:0] word;
        logic              wr;
        logic [WAY_W-1:0]  way;
        logic [TAG_W-1:0]  vtag;
        logic [BEAT_W-1:0] fbeat;
        logic [WAY_W-1:0]  rr;
        logic              resume;
        logic [BUS_W-1:0]  rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WAY_W-1:0]  pick_way;
    logic              all_valid;
    logic [BEAT_W-1:0] wb_beat;
    logic              wb_end;
    logic              wb_last;
    logic              in_wb;
    logic              miss_seen;

    assign in_wb     = (ctl_q.st == MS_WBACK);
    assign miss_seen = lk_valid_i & ~lk_hit_i;

    mfc_way_pick #(.WAYS(WAYS)) u_pick (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .valid_i     (tag_rd_valid_i),
        .rr_i        (ctl_q.rr),
        .way_o       (pick_way),
        .all_valid_o (all_valid)
    );

    mfc_beat_seq #(.BEATS(BEATS), .BEAT_CYC(BEAT_CYC)) u_wbseq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (in_wb),
        .beat_o     (wb_beat),
        .beat_end_o (wb_end),
        .last_o     (wb_last)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.resume = 1'b0;
        unique case (ctl_q.st)
            MS_IDLE: begin
                if (miss_seen) begin
                    ctl_d.tag  = lk_addr_i[ADDR_W-1 -: TAG_W];
                    ctl_d.set  = lk_addr_i[OFF_W +: IDX_W];
                    ctl_d.word = lk_addr_i[BOFF_W +: BEAT_W];
                    ctl_d.wr   = lk_write_i;
                    ctl_d.st   = MS_VICTIM;
                end
            end
            MS_VICTIM: begin
                ctl_d.way  = pick_way;
                ctl_d.vtag = tag_rd_tag_i[int'(pick_way)*TAG_W +: TAG_W];
                if (all_valid) begin
                    ctl_d.rr = (ctl_q.rr == WAY_W'(WAYS - 1)) ? '0 : ctl_q.rr + 1'b1;
                end
                if (tag_rd_valid_i[pick_way] && tag_rd_dirty_i[pick_way]) ctl_d.st = MS_WBACK;
                else                                                      ctl_d.st = MS_REQ;
            end
            MS_WBACK: begin
                if (wb_last) ctl_d.st = MS_REQ;
            end
            MS_REQ: begin
                ctl_d.fbeat = '0;
                ctl_d.st    = MS_WAIT;
            end
            MS_WAIT: begin
                if (nl_rvalid_i) begin
                    if (ctl_q.fbeat == ctl_q.word) ctl_d.rdata = nl_rdata_i;
                    ctl_d.fbeat = ctl_q.fbeat + 1'b1;
                    if (ctl_q.fbeat == BEAT_W'(BEATS - 1)) ctl_d.st = MS_FILL;
                end
            end
            MS_FILL: begin
                ctl_d.resume = 1'b1;
                ctl_d.st     = MS_IDLE;
            end
            default: ctl_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign stall_o       = (ctl_q.st == MS_IDLE) ? miss_seen : 1'b1;
    assign resume_o      = ctl_q.resume;
    assign resume_data_o = ctl_q.rdata;
    assign arr_set_o     = ctl_q.set;
    assign arr_way_o     = ctl_q.way;
    assign data_beat_o   = in_wb ? wb_beat : ctl_q.fbeat;
    assign data_we_o     = (ctl_q.st == MS_WAIT) & nl_rvalid_i;
    assign data_wdata_o  = nl_rdata_i;
    assign tag_we_o      = (ctl_q.st == MS_FILL);
    assign tag_wtag_o    = ctl_q.tag;
    assign tag_wvalid_o  = (ctl_q.st == MS_FILL);
    assign tag_wdirty_o  = ctl_q.wr;
    assign nl_req_o      = (ctl_q.st == MS_REQ);
    assign nl_we_o       = in_wb;
    assign nl_wvalid_o   = wb_end;
    assign nl_wdata_o    = data_rdata_i;
    assign nl_addr_o     = in_wb ? {ctl_q.vtag, ctl_q.set, OFF_W'(0)}
                                 : {ctl_q.tag,  ctl_q.set, OFF_W'(0)};

    // R2: the line request is a single-cycle pulse
    a_r2_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nl_req_o |=> !nl_req_o);
    // R3: the end of a writeback is followed at once by the request
    a_r3_req_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(nl_we_o) |-> nl_req_o);
    // R5: the tag write comes right after a data beat was stored
    a_r5_tag_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tag_we_o |-> $past(data_we_o));
    // R6: resume follows the tag write by one cycle
    a_r6_resume_after_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resume_o |-> $past(tag_we_o));
    // R8: array writes only happen while the core is held
    a_r8_write_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_we_o |-> stall_o);
endmodule

// File: tb/mfc_linefill_ctrl_tb_top.sv
module mfc_linefill_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS     = 4;
    localparam int SETS     = 64;
    localparam int BEATS    = 4;
    localparam int BEAT_CYC = 2;
    localparam int REQ_LAT  = 10;
    localparam int TAG_W    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0, lk_hit = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_addr = '0;
    logic stall_o, resume_o;
    logic [127:0] resume_data_o;
    logic [5:0] arr_set_o;
    logic [1:0] arr_way_o;
    logic [WAYS-1:0] tag_rd_valid, tag_rd_dirty;
    logic [WAYS*TAG_W-1:0] tag_rd_tag;
    logic tag_we_o, tag_wvalid_o, tag_wdirty_o;
    logic [TAG_W-1:0] tag_wtag_o;
    logic [1:0] data_beat_o;
    logic [127:0] data_rdata;
    logic data_we_o;
    logic [127:0] data_wdata_o;
    logic nl_req_o, nl_we_o, nl_wvalid_o;
    logic [31:0] nl_addr_o;
    logic [127:0] nl_wdata_o;
    logic nl_rvalid = 1'b0;
    logic [127:0] nl_rdata = '0;

    logic [WAYS-1:0]  tv [SETS];
    logic [WAYS-1:0]  td [SETS];
    logic [TAG_W-1:0] tt [SETS][WAYS];
    logic [127:0]     dmem [SETS*WAYS*BEATS];

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int stall_n, req_n, req_cyc, wb_n, dw_n, tw_n, res_n, res_cyc;
    logic [31:0] req_addr, rv_addr;
    logic req_we;
    int wb_cyc [8];
    logic [31:0] wb_addr [8];
    logic [127:0] wb_data [8];
    int dw_beat [8], dw_way [8], dw_set [8];
    logic [127:0] dw_data [8];
    logic [TAG_W-1:0] tw_tag;
    int tw_way, tw_set;
    logic tw_valid, tw_dirty;
    logic [127:0] res_data;
    int rv_base = -1;
    bit rv_force = 1'b0;

    mfc_linefill_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .lk_valid_i(lk_valid), .lk_hit_i(lk_hit), .lk_write_i(lk_write), .lk_addr_i(lk_addr),
        .stall_o(stall_o), .resume_o(resume_o), .resume_data_o(resume_data_o),
        .arr_set_o(arr_set_o), .arr_way_o(arr_way_o),
        .tag_rd_valid_i(tag_rd_valid), .tag_rd_dirty_i(tag_rd_dirty), .tag_rd_tag_i(tag_rd_tag),
        .tag_we_o(tag_we_o), .tag_wtag_o(tag_wtag_o), .tag_wvalid_o(tag_wvalid_o),
        .tag_wdirty_o(tag_wdirty_o),
        .data_beat_o(data_beat_o), .data_rdata_i(data_rdata), .data_we_o(data_we_o),
        .data_wdata_o(data_wdata_o),
        .nl_req_o(nl_req_o), .nl_we_o(nl_we_o), .nl_addr_o(nl_addr_o),
        .nl_wvalid_o(nl_wvalid_o), .nl_wdata_o(nl_wdata_o),
        .nl_rvalid_i(nl_rvalid), .nl_rdata_i(nl_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int didx(int s, int w, int b);
        return (s * WAYS + w) * BEATS + b;
    endfunction
    function automatic logic [127:0] dinit(int s, int w, int b);
        return {16'hD1D1, 16'(s), 16'(w), 16'(b), 64'h0123_4567_89AB_CDEF};
    endfunction
    function automatic logic [127:0] nd(logic [31:0] a, int k);
        return {a, 32'hA5A5_0000 + 32'(k), ~a, 32'h0000_5A5A ^ 32'(k)};
    endfunction

    assign tag_rd_valid = tv[arr_set_o];
    assign tag_rd_dirty = td[arr_set_o];
    assign data_rdata   = dmem[didx(int'(arr_set_o), int'(arr_way_o), int'(data_beat_o))];
    always_comb begin
        for (int w = 0; w < WAYS; w++) tag_rd_tag[w*TAG_W +: TAG_W] = tt[arr_set_o][w];
    end

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_rec();
        stall_n = 0; req_n = 0; req_cyc = -1; wb_n = 0; dw_n = 0; tw_n = 0;
        res_n = 0; res_cyc = -1; rv_base = -1;
    endtask

    // next-level model and output recorder
    always begin
        @(negedge clk);
        #1;
        nl_rvalid = 1'b0;
        nl_rdata  = '0;
        if (rv_base >= 0) begin
            for (int k = 0; k < BEATS; k++) begin
                if (cyc == rv_base + REQ_LAT + BEAT_CYC * (k + 1)) begin
                    nl_rvalid = 1'b1;
                    nl_rdata  = nd(rv_addr, k);
                end
            end
        end
        if (rv_force) begin
            nl_rvalid = 1'b1;
            nl_rdata  = '1;
        end
        #1;
        if (rst_n) begin
            if (stall_o) stall_n++;
            if (nl_req_o) begin
                req_n++; req_cyc = cyc; req_addr = nl_addr_o; req_we = nl_we_o;
                rv_base = cyc; rv_addr = nl_addr_o;
            end
            if (nl_wvalid_o) begin
                if (wb_n < 8) begin
                    wb_cyc[wb_n] = cyc; wb_addr[wb_n] = nl_addr_o; wb_data[wb_n] = nl_wdata_o;
                end
                wb_n++;
            end
            if (data_we_o) begin
                if (dw_n < 8) begin
                    dw_beat[dw_n] = int'(data_beat_o); dw_way[dw_n] = int'(arr_way_o);
                    dw_set[dw_n] = int'(arr_set_o); dw_data[dw_n] = data_wdata_o;
                end
                dw_n++;
                dmem[didx(int'(arr_set_o), int'(arr_way_o), int'(data_beat_o))] = data_wdata_o;
            end
            if (tag_we_o) begin
                tw_n++; tw_tag = tag_wtag_o; tw_way = int'(arr_way_o); tw_set = int'(arr_set_o);
                tw_valid = tag_wvalid_o; tw_dirty = tag_wdirty_o;
                tv[arr_set_o][arr_way_o] = tag_wvalid_o;
                td[arr_set_o][arr_way_o] = tag_wdirty_o;
                tt[arr_set_o][arr_way_o] = tag_wtag_o;
            end
            if (resume_o) begin
                res_n++; res_cyc = cyc; res_data = resume_data_o;
            end
        end
    end

    // drive one miss and check the whole sequence it produces
    task automatic run_miss(logic [31:0] addr, logic wr, bit hold_other, logic [31:0] other,
                            int exp_way, bit dirty_vic, logic [TAG_W-1:0] vtag);
        int det, wbx, exp_req;
        logic [31:0] line, vline;
        int set, word;
        line  = {addr[31:6], 6'b0};
        set   = int'(addr[11:6]);
        word  = int'(addr[5:4]);
        vline = {vtag, addr[11:6], 6'b0};
        clear_rec();
        @(negedge clk);
        lk_valid = 1'b1; lk_hit = 1'b0; lk_write = wr; lk_addr = addr;
        det = cyc;
        @(negedge clk);
        if (hold_other) begin
            lk_addr = other; lk_write = 1'b0;
            repeat (5) @(negedge clk);
        end
        lk_valid = 1'b0;
        for (int i = 0; i < 200 && res_n == 0; i++) begin
            @(negedge clk);
            #3;
        end
        wbx     = dirty_vic ? BEATS * BEAT_CYC : 0;
        exp_req = det + 2 + wbx;
        // R2 / R3: request timing and address
        check("R2 request count", req_n, 1);
        check("R2 request cycle", req_cyc, exp_req);
        check("R2 request address", req_addr, line);
        check("R2 request is a read", req_we, 0);
        check("R3 writeback beat count", wb_n, dirty_vic ? BEATS : 0);
        if (dirty_vic) begin
            for (int k = 0; k < BEATS; k++) begin
                check("R3 writeback beat cycle", wb_cyc[k], det + 2 + BEAT_CYC * k + BEAT_CYC - 1);
                check("R3 writeback address", wb_addr[k], vline);
                check("R3 writeback data", wb_data[k], dinit(set, exp_way, k));
            end
        end
        // R4: fill beats in order into the chosen way
        check("R4 fill beat count", dw_n, BEATS);
        for (int k = 0; k < BEATS; k++) begin
            check("R4 fill beat index", dw_beat[k], k);
            check("R4 fill way", dw_way[k], exp_way);
            check("R4 fill set", dw_set[k], set);
            check("R4 fill data", dw_data[k], nd(line, k));
        end
        // R5: tag entry
        check("R5 tag write count", tw_n, 1);
        check("R5 tag value", tw_tag, addr[31:12]);
        check("R5 tag valid", tw_valid, 1);
        check("R5 tag dirty", tw_dirty, wr);
        check("R7 victim way", tw_way, exp_way);
        // R6: stall length and resume word
        check("R6 stall cycles", stall_n, exp_req - det + REQ_LAT + BEATS * BEAT_CYC + 2);
        check("R6 resume cycle", res_cyc, exp_req + REQ_LAT + BEATS * BEAT_CYC + 2);
        check("R6 resume word", res_data, nd(line, word));
        check("R6 stall dropped", stall_o, 0);
    endtask

    task automatic t_reset();
        check("R1 stall in reset", stall_o, 0);
        check("R1 request in reset", nl_req_o, 0);
        check("R1 writes in reset", {tag_we_o, data_we_o, nl_we_o, nl_wvalid_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        check("R1 stall after reset", stall_o, 0);
        check("R1 resume after reset", resume_o, 0);
        check("R1 request after reset", nl_req_o, 0);
        check("R1 writes after reset", {tag_we_o, data_we_o, nl_we_o, nl_wvalid_o}, 0);
    endtask

    task automatic t_hit_ignored();
        clear_rec();
        @(negedge clk);
        lk_valid = 1'b1; lk_hit = 1'b1; lk_addr = 32'h1234_5678;
        #3;
        check("R8 hit gives no stall", stall_o, 0);
        repeat (4) @(negedge clk);
        lk_valid = 1'b0; lk_hit = 1'b0;
        repeat (20) @(negedge clk);
        #3;
        check("R8 hit gives no request", req_n, 0);
        check("R8 hit gives no tag write", tw_n, 0);
    endtask

    task automatic t_stray_rvalid();
        clear_rec();
        @(negedge clk);
        rv_force = 1'b1;
        repeat (3) @(negedge clk);
        rv_force = 1'b0;
        repeat (2) @(negedge clk);
        #3;
        check("R8 stray beat not stored", dw_n, 0);
        check("R8 stray beat no stall", stall_n, 0);
        check("R8 stray beat no resume", res_n, 0);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            tv[s] = '0; td[s] = '0;
            for (int w = 0; w < WAYS; w++) begin
                tt[s][w] = '0;
                for (int b = 0; b < BEATS; b++) dmem[didx(s, w, b)] = dinit(s, w, b);
            end
        end
        clear_rec();
        repeat (3) @(negedge clk);
        t_reset();
        t_hit_ignored();
        // R7: empty set picks way 0; clean load miss
        run_miss({20'h12345, 6'd5, 6'h20}, 1'b0, 1'b0, '0, 0, 1'b0, '0);
        // R8: lookups during the miss are ignored; R7: next free way is 1
        run_miss({20'h00ABC, 6'd5, 6'h30}, 1'b0, 1'b1, {20'hFFFFF, 6'd7, 6'h00}, 1, 1'b0, '0);
        // R3: full set, way 0 dirty, round-robin pointer at 0
        tv[9] = 4'b1111; td[9] = 4'b0001;
        for (int w = 0; w < WAYS; w++) tt[9][w] = 20'h0A000 + 20'(w);
        run_miss({20'h77777, 6'd9, 6'h10}, 1'b1, 1'b0, '0, 0, 1'b1, 20'h0A000);
        // R7: pointer has moved to way 1, which is clean
        run_miss({20'h66666, 6'd9, 6'h00}, 1'b0, 1'b0, '0, 1, 1'b0, 20'h0A001);
        t_stray_rvalid();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule